// File: doc/BRIEF.md
# Fractional-Addend Time-of-Day Counter

This block keeps a 64-bit time of day in nanoseconds for a precision time protocol clock. A 32-bit phase accumulator runs on the reference clock and adds a programmable addend each cycle. Each carry out of the accumulator advances the nanosecond counter by a programmable tick period. Software trims the frequency by rewriting the addend while the counter runs, and this does not disturb the counter.

Two 64-bit alarm comparators raise sticky events when a tick carries the time to or past their programmed values. A periodic pulse generator is armed by the first alarm. Once that alarm is crossed, it emits a one-cycle pulse every (period register + tick period) nanoseconds. An external strobe input is latched as a fourth event. The interrupt line is the OR of the pending events that are also enabled in the mask. All registers sit on a simple word-addressed 32-bit register bus with a write strobe, a read strobe and a combinational read path.

Top module: `tod_clock`

## Requirements
- R1: After reset every register reads 0, and both `irq_o` and `pulse_o` are low.
- R2: While running, the accumulator adds the addend modulo 2^32 once per cycle. Each carry out advances the counter by the tick period exactly once, one cycle later. A cycle with no carry leaves the counter unchanged. Example: with addend 0x8000_0000 and tick 8, twenty running cycles starting from a zero accumulator give +80 ns.
- R3: With an addend of zero the counter does not move, even while running.
- R4: Clearing the run bit stops new carries, and the counter then holds its value.
- R5: Reading the counter low word captures the high word. A later read of the high word returns that captured value, even if the counter has since moved.
- R6: Writing the counter low word only stages it, so the counter is unchanged. Writing the high word loads {high, staged low} as one 64-bit update. This load takes priority over a tick in the same cycle.
- R7: An alarm event sets when a tick takes the counter from below the alarm value to at or above it. While the counter is still below the alarm value, the event stays clear.
- R8: The event register has bit 0 = alarm 1, bit 1 = alarm 2, bit 2 = pulse and bit 3 = external strobe. Bits are sticky and are cleared by writing 1. If a new event and a clear of the same bit arrive in the same cycle, the new event wins.
- R9: `irq_o` is high exactly when some event bit is set and its mask bit is also set.
- R10: With the arm bit set, the pulse generator goes live on the alarm-1 crossing. From then on it fires every (period + tick) ns of counted time, as a one-cycle `pulse_o`. Example: tick 8 and period 24 give pulses at alarm+32, alarm+64, and so on.
- R11: With the pulse-output enable clear, pulse events are still latched in bit 2, but `pulse_o` stays low.
- R12: A high `stamp_i` sets event bit 3.
- R13: The register map is as follows:
  - 0 control: bit 0 run, bit 1 pulse arm, bit 2 pulse output enable, bits [8 +: TICK_W] tick period.
  - 1 addend.
  - 2 counter low, 3 counter high.
  - 4/5 alarm-1 low/high, 6/7 alarm-2 low/high.
  - 8 pulse period.
  - 9 event, 10 mask.
  - Unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (drives the low-word snapshot) |
| reg_addr_i | input | 4 | Register word address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, combinational from the address |
| stamp_i | input | 1 | External timestamp strobe |
| irq_o | output | 1 | Interrupt, OR of masked events |
| pulse_o | output | 1 | Periodic one-cycle pulse |

## Verification
The counter is driven with a half-scale addend, which gives a carry every other cycle, and with a zero addend, which gives none. Together these separate a correct carry-gated step from a counter that runs free or never moves. Runs that cross the 32-bit boundary, combined with reads of the high word before and after a fresh low read, separate a snapshot from a live high word. Alarm runs stop one tick short of the compare value and then on it, which exposes off-by-one compares. Pulse counts taken with and without the output enable distinguish the event path from the pin path, and a strobe landing in the same cycle as its own clear checks that a set wins.

// File: rtl/tod_clock.sv
module tod_clock #(
  parameter int TICK_W = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_wr_i,
  input  logic        reg_rd_i,
  input  logic [3:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  input  logic        stamp_i,
  output logic        irq_o,
  output logic        pulse_o
);
  localparam logic [3:0] A_CTRL = 4'd0, A_ADD = 4'd1, A_CLO = 4'd2, A_CHI = 4'd3,
                         A_A1L = 4'd4, A_A1H = 4'd5, A_A2L = 4'd6, A_A2H = 4'd7,
                         A_PER = 4'd8, A_EVT = 4'd9, A_MSK = 4'd10;

  logic              run_q, arm_q, oe_q;
  logic [TICK_W-1:0] tick_q;
  logic [31:0]       addend_q, acc_q, lo_stage_q, hi_snap_q, period_q, elapsed_q;
  logic [63:0]       cnt_q, alm1_q, alm2_q;
  logic [3:0]        ev_q, mask_q;
  logic              carry_q, live_q, pulse_q;

  wire         cnt_commit = reg_wr_i && reg_addr_i == A_CHI;
  wire         step       = carry_q && !cnt_commit;
  wire  [63:0] cnt_next   = cnt_q + 64'(tick_q);
  wire         alm1_hit   = step && cnt_q < alm1_q && cnt_next >= alm1_q;
  wire         alm2_hit   = step && cnt_q < alm2_q && cnt_next >= alm2_q;
  wire         pstep      = step && live_q && arm_q;
  wire         fire       = pstep && elapsed_q >= period_q;
  wire  [3:0]  ev_set     = {stamp_i, fire, alm2_hit, alm1_hit};
  wire  [3:0]  ev_clr     = (reg_wr_i && reg_addr_i == A_EVT) ? reg_wdata_i[3:0] : 4'd0;

  assign irq_o   = |(ev_q & mask_q);
  assign pulse_o = pulse_q & oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      carry_q <= 1'b0;
    end else if (run_q) begin
      {carry_q, acc_q} <= {1'b0, acc_q} + {1'b0, addend_q};
    end else begin
      carry_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_commit) begin
      cnt_q <= {reg_wdata_i, lo_stage_q};
    end else if (carry_q) begin
      cnt_q <= cnt_next;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0; arm_q <= 1'b0; oe_q <= 1'b0; tick_q <= '0;
      addend_q <= '0; lo_stage_q <= '0; period_q <= '0;
      alm1_q <= '0; alm2_q <= '0; mask_q <= '0;
    end else if (reg_wr_i) begin
      case (reg_addr_i)
        A_CTRL: begin
          run_q  <= reg_wdata_i[0];
          arm_q  <= reg_wdata_i[1];
          oe_q   <= reg_wdata_i[2];
          tick_q <= reg_wdata_i[8 +: TICK_W];
        end
        A_ADD:   addend_q          <= reg_wdata_i;
        A_CLO:   lo_stage_q        <= reg_wdata_i;
        A_A1L:   alm1_q[31:0]      <= reg_wdata_i;
        A_A1H:   alm1_q[63:32]     <= reg_wdata_i;
        A_A2L:   alm2_q[31:0]      <= reg_wdata_i;
        A_A2H:   alm2_q[63:32]     <= reg_wdata_i;
        A_PER:   period_q          <= reg_wdata_i;
        A_MSK:   mask_q            <= reg_wdata_i[3:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_snap_q <= '0;
    end else if (reg_rd_i && reg_addr_i == A_CLO) begin
      hi_snap_q <= cnt_q[63:32];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      live_q    <= 1'b0;
      elapsed_q <= '0;
      pulse_q   <= 1'b0;
      ev_q      <= '0;
    end else begin
      pulse_q <= fire;
      ev_q    <= (ev_q & ~ev_clr) | ev_set;
      if (!arm_q) begin
        live_q    <= 1'b0;
        elapsed_q <= '0;
      end else if (!live_q) begin
        live_q    <= alm1_hit;
        elapsed_q <= '0;
      end else if (pstep) begin
        elapsed_q <= fire ? elapsed_q - period_q : elapsed_q + 32'(tick_q);
      end
    end
  end

  always_comb begin
    case (reg_addr_i)
      A_CTRL:  reg_rdata_o = 32'({tick_q, 5'd0, oe_q, arm_q, run_q});
      A_ADD:   reg_rdata_o = addend_q;
      A_CLO:   reg_rdata_o = cnt_q[31:0];
      A_CHI:   reg_rdata_o = hi_snap_q;
      A_A1L:   reg_rdata_o = alm1_q[31:0];
      A_A1H:   reg_rdata_o = alm1_q[63:32];
      A_A2L:   reg_rdata_o = alm2_q[31:0];
      A_A2H:   reg_rdata_o = alm2_q[63:32];
      A_PER:   reg_rdata_o = period_q;
      A_EVT:   reg_rdata_o = {28'd0, ev_q};
      A_MSK:   reg_rdata_o = {28'd0, mask_q};
      default: reg_rdata_o = '0;
    endcase
  end
endmodule

module tod_clock_chk #(
  parameter int TICK_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_wr_i,
  input logic [3:0]        reg_addr_i,
  input logic [31:0]       reg_wdata_i,
  input logic              run_q,
  input logic              carry_q,
  input logic [TICK_W-1:0] tick_q,
  input logic [63:0]       cnt_q,
  input logic [3:0]        ev_q,
  input logic              irq_o
);
  wire commit = reg_wr_i && reg_addr_i == 4'd3;
  wire ev_wr  = reg_wr_i && reg_addr_i == 4'd9;

  assert_tick_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (carry_q && !commit) |=> cnt_q == $past(cnt_q) + 64'($past(tick_q)));

  assert_no_carry_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!carry_q && !commit) |=> $stable(cnt_q));

  assert_stop_no_carry_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q |=> !carry_q);

  assert_atomic_load_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit |=> cnt_q[63:32] == $past(reg_wdata_i));

  assert_sticky_event_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ev_wr |=> (ev_q & $past(ev_q)) == $past(ev_q));

  assert_irq_needs_event_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ev_q != 4'd0);
endmodule

bind tod_clock tod_clock_chk #(.TICK_W(TICK_W)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i),
  .reg_wdata_i(reg_wdata_i), .run_q(run_q), .carry_q(carry_q), .tick_q(tick_q),
  .cnt_q(cnt_q), .ev_q(ev_q), .irq_o(irq_o)
);

// File: tb/tod_clock_tb_top.sv
`timescale 1ns/1ps
module tod_clock_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0, rd = 1'b0, stamp = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, pulse;

  int n_cmp = 0, n_bad = 0, n_pulses = 0;
  bit done = 1'b0;

  typedef struct { logic [31:0] exp; string tag; } item_t;
  item_t sb_q[$];

  always #2 clk = ~clk;

  tod_clock #(.TICK_W(8)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr), .reg_rd_i(rd), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .stamp_i(stamp), .irq_o(irq), .pulse_o(pulse)
  );

  localparam logic [31:0] TK = 32'h800;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(logic [3:0] a, logic [31:0] d);
    wr = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    wr = 1'b0;
  endtask

  task automatic rd_exp(logic [3:0] a, logic [31:0] e, string tag);
    item_t it;
    it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    rd = 1'b1; addr = a;
    @(posedge clk); #1;
    rd = 1'b0;
  endtask

  task automatic run_for(int n, logic [31:0] on_v, logic [31:0] off_v);
    wr_reg(4'd0, on_v);
    repeat (n) @(posedge clk);
    #1;
    wr_reg(4'd0, off_v);
    repeat (3) @(posedge clk);
    #1;
  endtask

  always @(negedge clk) begin
    if (rd) begin
      if (sb_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL scoreboard: read with no expected item, actual %0h expected none", rdata);
      end else begin
        item_t it;
        it = sb_q.pop_front();
        chk(it.tag, rdata, it.exp);
      end
    end
    if (pulse) n_pulses++;
  end

  initial begin
    #400000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    chk("R1 irq", 32'(irq), 0);
    chk("R1 pulse", 32'(pulse), 0);
    rd_exp(4'd0, 0, "R1 ctrl");
    rd_exp(4'd9, 0, "R1 event");
    rd_exp(4'd2, 0, "R1 cnt lo");
    // R2: half-scale addend, 20 running cycles -> 10 ticks of 8 ns
    wr_reg(4'd1, 32'h8000_0000);
    rd_exp(4'd1, 32'h8000_0000, "R13 addend readback");
    run_for(19, TK | 1, TK);
    rd_exp(4'd2, 80, "R2 count after 10 carries");
    rd_exp(4'd3, 0, "R5 hi after lo read");
    // R4 stopped counter holds
    repeat (10) @(posedge clk);
    #1;
    rd_exp(4'd2, 80, "R4 hold while stopped");
    // R3 zero addend
    wr_reg(4'd1, 0);
    run_for(9, TK | 1, TK);
    rd_exp(4'd2, 80, "R3 zero addend");
    // R6 staged low, atomic commit
    wr_reg(4'd2, 32'h55);
    rd_exp(4'd2, 80, "R6 low write staged only");
    wr_reg(4'd3, 7);
    rd_exp(4'd2, 32'h55, "R6 commit low");
    rd_exp(4'd3, 7, "R6 commit high");
    // R5 snapshot across a 32-bit carry
    wr_reg(4'd2, 32'hFFFF_FFF0);
    wr_reg(4'd3, 1);
    rd_exp(4'd2, 32'hFFFF_FFF0, "R5 lo before wrap");
    wr_reg(4'd1, 32'h8000_0000);
    run_for(3, TK | 1, TK);
    rd_exp(4'd3, 1, "R5 hi is snapshot");
    rd_exp(4'd2, 0, "R5 lo after wrap");
    rd_exp(4'd3, 2, "R5 hi fresh");
    // R7 alarms, R9 irq, R8 W1C
    wr_reg(4'd2, 1000);
    wr_reg(4'd3, 0);
    wr_reg(4'd4, 1040);
    wr_reg(4'd5, 0);
    wr_reg(4'd6, 1100);
    wr_reg(4'd7, 0);
    wr_reg(4'd8, 24);
    wr_reg(4'd10, 1);
    run_for(7, TK | 7, TK | 6);
    rd_exp(4'd9, 0, "R7 alarm not yet reached");
    chk("R9 irq low before alarm", 32'(irq), 0);
    run_for(1, TK | 7, TK | 6);
    rd_exp(4'd9, 1, "R7 alarm1 crossed");
    chk("R9 irq on masked alarm", 32'(irq), 1);
    wr_reg(4'd9, 1);
    rd_exp(4'd9, 0, "R8 write-one clear");
    chk("R9 irq after clear", 32'(irq), 0);
    // R10 periodic pulse
    n_pulses = 0;
    run_for(31, TK | 7, TK | 6);
    chk("R10 pulse count over 128 ns", 32'(n_pulses), 4);
    rd_exp(4'd2, 1168, "R2 count after 16 ticks");
    rd_exp(4'd9, 6, "R8 alarm2 and pulse events");
    // R11 output disabled
    wr_reg(4'd9, 32'hF);
    run_for(7, TK | 3, TK | 2);
    chk("R11 pin silent", 32'(n_pulses), 4);
    rd_exp(4'd9, 4, "R11 pulse event still latched");
    // R12 strobe
    wr_reg(4'd10, 8);
    stamp = 1'b1;
    @(posedge clk); #1;
    stamp = 1'b0;
    rd_exp(4'd9, 32'hC, "R12 strobe event");
    chk("R9 irq on strobe", 32'(irq), 1);
    wr_reg(4'd10, 0);
    chk("R9 irq masked off", 32'(irq), 0);
    // R8 set wins over clear
    wr = 1'b1; addr = 4'd9; wdata = 8; stamp = 1'b1;
    @(posedge clk); #1;
    wr = 1'b0; stamp = 1'b0;
    rd_exp(4'd9, 32'hC, "R8 set wins");
    wr_reg(4'd9, 32'hF);
    rd_exp(4'd9, 0, "R8 clear all");
    // R13 map
    rd_exp(4'd8, 24, "R13 period readback");
    rd_exp(4'd15, 0, "R13 unused reads zero");
    wr_reg(4'd0, 0);
    rd_exp(4'd0, 0, "R13 ctrl cleared");
    repeat (2) @(posedge clk);
    #1;
    if (sb_q.size() != 0) chk("scoreboard drained", 32'(sb_q.size()), 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule